// File: doc/BRIEF.md
# Clock Divider Parameter Search Engine

This block picks the settings of a fixed-ratio clock generator that come closest to a requested frequency. The generator takes a 24 MHz crystal multiplied by 12 or by 14. It divides that source by an odd factor, then by a power of two, and optionally by a further factor of two. Given a target in kHz, the engine works through every permitted combination in a fixed order. It computes each candidate's output frequency with an iterative restoring divider and keeps the candidate with the smallest absolute error. At the end it reports the encoded control fields and the error.

A pulse on `start` captures the request and the two mode inputs, and `busy` rises. The result fields become valid in the cycle where `done` pulses, and they stay unchanged until the next accepted start. A memory-clock mode narrows the search: it uses only the two smallest odd factors and drops the extra halving stage.

Top module: `clkdiv_search`

## Requirements
- R1: After reset, `busy` and `done` are 0, `err_khz` is 0x7FFFFFFF, and `src_sel`, `div_code`, `shift_amt` and `one_x` are all 0.
- R2: A candidate's frequency is the source (288000 kHz when `src_sel`=0, 336000 kHz when `src_sel`=1) divided by (odd << shift << half), truncated to an integer. The odd factor is 1, 3 or 5 and the shift runs 0 to 7.
- R3: Outside memory mode, the extra halving (half=1) is tried first for each shift. half=0 is tried afterwards only when `allow_1x` is 1. `one_x` reports 1 exactly when the winner has half=0.
- R4: `div_code` encodes the odd factor: 0 for 1, 1 for 3, 2 for 5. It never takes the value 3.
- R5: A candidate replaces the best so far only when its error is strictly smaller, so on equal error the earlier candidate wins. The loops run from outermost to innermost as multiplier, odd factor, shift, halving.
- R6: With `mem_mode`=1, only odd factors 1 and 3 are tried, each divided by (odd << shift) with no halving. `one_x` is then 0.
- R7: `err_khz` is |candidate frequency − request| in kHz. The starting best error is 0x7FFFFFFF. If no candidate beats it, the fields stay 0 and the error stays 0x7FFFFFFF.
- R8: Each candidate takes 34 clock cycles. `done` rises exactly 34·N cycles after the edge that accepts `start`, where N = 2 × (odd factors tried) × 8 × (halving values tried). `busy` is high from that edge until `done`.
- R9: `done` is a single-cycle pulse. After it, the outputs hold their values until the next accepted start. A `start` raised while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search; accepted only when idle |
| req_khz | input | 32 | Requested frequency in kHz |
| allow_1x | input | 1 | Permit candidates without the extra halving |
| mem_mode | input | 1 | Restricted memory-clock search |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse at the end of a search |
| src_sel | output | 1 | 0 = 12x source, 1 = 14x source |
| div_code | output | 2 | Encoded odd factor |
| shift_amt | output | 3 | Power-of-two shift |
| one_x | output | 1 | Winner skips the extra halving |
| err_khz | output | 32 | Absolute error of the winner in kHz |

## Verification
The result fields are due in the cycle where `done` is high, and that pulse is due exactly 34·N cycles after the accepting edge. The bench therefore counts rising edges from the accepting edge and samples on falling edges. For each request it compares the measured count against 34·N, which it works out from the mode inputs. It reads the fields on the same falling edge where `done` is first seen, then reads them again several cycles later to confirm they are still held. A second start is raised partway through a search, and the bench confirms that the latency and the result both still belong to the first request.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int unsigned FREQ_W   = 32;
    localparam int unsigned XTAL_KHZ = 24000;
    localparam int unsigned SHIFT_W  = 3;
    localparam logic [FREQ_W-1:0] ERR_INIT = 32'h7FFF_FFFF;

    // One point in the search space.
    typedef struct packed {
        logic               sel;       // 0: x12, 1: x14
        logic [1:0]         div_code;  // 0:1, 1:3, 2:5
        logic [SHIFT_W-1:0] shift;
        logic               half;      // 1: extra divide by two
    } cand_t;

    // Reported winner.
    typedef struct packed {
        logic               sel;
        logic [1:0]         div_code;
        logic [SHIFT_W-1:0] shift;
        logic               one_x;
    } result_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GO,
        ST_WAIT
    } state_t;

    function automatic logic [2:0] odd_value(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd3;
            default: return 3'd5;
        endcase
    endfunction

    function automatic logic [FREQ_W-1:0] src_khz(input logic sel);
        return sel ? FREQ_W'(XTAL_KHZ * 14) : FREQ_W'(XTAL_KHZ * 12);
    endfunction

endpackage

// File: rtl/clkdiv_divu.sv
module clkdiv_divu #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] quo,
    output logic         vld
);
    localparam int unsigned CW = $clog2(W);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic [W:0]    rem_sh;
    logic [W:0]    rem_sub;
    logic          ge;

    always_comb begin
        rem_sh  = {rem_q, quo_q[W-1]};
        ge      = rem_sh >= {1'b0, den};
        rem_sub = rem_sh - {1'b0, den};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            vld    <= 1'b0;
        end else begin
            vld <= 1'b0;
            if (go) begin
                rem_q  <= '0;
                quo_q  <= num;
                cnt_q  <= '0;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= ge ? rem_sub[W-1:0] : rem_sh[W-1:0];
                quo_q <= {quo_q[W-2:0], ge};
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CW'(W - 1)) begin
                    busy_q <= 1'b0;
                    vld    <= 1'b1;
                end
            end
        end
    end

    assign quo = quo_q;

    // R8: a new division is never launched over one in flight
    assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
        !(go && busy_q));
    // R8: the quotient-valid strobe lasts one cycle
    assert_vld_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        vld |=> !vld);

endmodule

// File: rtl/clkdiv_walk.sv
module clkdiv_walk
    import clkdiv_pkg::*;
#(
    parameter int unsigned MAX_CODE = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  init,
    input  logic  step,
    input  logic  mem_in,
    input  logic  allow_in,
    output cand_t cand,
    output logic  mem_q,
    output logic  last
);
    localparam logic [1:0] CODE_TOP = 2'(MAX_CODE);
    localparam logic [1:0] MEM_TOP  = (MAX_CODE >= 1) ? 2'd1 : 2'd0;
    localparam logic [SHIFT_W-1:0] SHIFT_TOP = '1;

    logic       allow_q;
    logic [1:0] div_top;
    logic       half_first;
    logic       half_end;

    always_comb begin
        div_top    = mem_q ? MEM_TOP : CODE_TOP;
        half_first = !mem_q;
        // Halving is the innermost loop: 1 then (if permitted) 0.
        half_end   = !cand.half || !(allow_q && !mem_q);
        last       = half_end && (cand.shift == SHIFT_TOP)
                     && (cand.div_code == div_top) && cand.sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cand    <= '0;
            mem_q   <= 1'b0;
            allow_q <= 1'b0;
        end else if (init) begin
            mem_q         <= mem_in;
            allow_q       <= allow_in;
            cand.sel      <= 1'b0;
            cand.div_code <= 2'd0;
            cand.shift    <= '0;
            cand.half     <= !mem_in;
        end else if (step) begin
            if (!half_end) begin
                cand.half <= 1'b0;
            end else begin
                cand.half <= half_first;
                if (cand.shift != SHIFT_TOP) begin
                    cand.shift <= cand.shift + 1'b1;
                end else begin
                    cand.shift <= '0;
                    if (cand.div_code != div_top) begin
                        cand.div_code <= cand.div_code + 2'd1;
                    end else begin
                        cand.div_code <= 2'd0;
                        cand.sel      <= !cand.sel;
                    end
                end
            end
        end
    end

    // R4: the odd-factor code stays inside the permitted range
    assert_code_range_R4: assert property (@(posedge clk) disable iff (rst)
        cand.div_code <= CODE_TOP);
    // R6: memory mode never visits the halving stage or the factor 5
    assert_mem_space_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_q && !init) |-> (!cand.half && cand.div_code <= 2'd1));

endmodule

// File: rtl/clkdiv_best.sv
module clkdiv_best
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              upd,
    input  cand_t             cand,
    input  logic              mem,
    input  logic [FREQ_W-1:0] freq,
    input  logic [FREQ_W-1:0] req,
    output result_t           best,
    output logic [FREQ_W-1:0] best_err
);
    logic [FREQ_W-1:0] err_now;
    logic              take;

    always_comb begin
        err_now = (freq >= req) ? (freq - req) : (req - freq);
        take    = upd && (err_now < best_err);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            best     <= '0;
            best_err <= ERR_INIT;
        end else if (take) begin
            best.sel      <= cand.sel;
            best.div_code <= cand.div_code;
            best.shift    <= cand.shift;
            best.one_x    <= !cand.half && !mem;
            best_err      <= err_now;
        end
    end

    // R5: the kept error never grows during a search
    assert_err_monotone_R5: assert property (@(posedge clk) disable iff (rst)
        (upd && !clear) |=> best_err <= $past(best_err));
    // R7: the kept error never exceeds the starting bound
    assert_err_bound_R7: assert property (@(posedge clk) disable iff (rst)
        best_err <= ERR_INIT);

endmodule

// File: rtl/clkdiv_search.sv
module clkdiv_search
    import clkdiv_pkg::*;
#(
    parameter int unsigned MAX_DIV = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] req_khz,
    input  logic        allow_1x,
    input  logic        mem_mode,
    output logic        busy,
    output logic        done,
    output logic        src_sel,
    output logic [1:0]  div_code,
    output logic [2:0]  shift_amt,
    output logic        one_x,
    output logic [31:0] err_khz
);
    localparam int unsigned MAX_CODE = (MAX_DIV >= 5) ? 2 : ((MAX_DIV >= 3) ? 1 : 0);

    state_t            state_q;
    logic [FREQ_W-1:0] req_q;
    cand_t             cand;
    logic              mem_q;
    logic              last;
    logic              accept;
    logic              div_go;
    logic              div_vld;
    logic              step;
    logic [FREQ_W-1:0] den;
    logic [FREQ_W-1:0] quo;
    result_t           best;

    always_comb begin
        accept = (state_q == ST_IDLE) && start;
        div_go = (state_q == ST_GO);
        step   = (state_q == ST_WAIT) && div_vld && !last;
        den    = FREQ_W'(odd_value(cand.div_code)) << cand.shift << cand.half;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        req_q   <= req_khz;
                        state_q <= ST_GO;
                    end
                end
                ST_GO: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (div_vld) begin
                        if (last) begin
                            done    <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_GO;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    clkdiv_walk #(.MAX_CODE(MAX_CODE)) u_walk (
        .clk      (clk),
        .rst      (rst),
        .init     (accept),
        .step     (step),
        .mem_in   (mem_mode),
        .allow_in (allow_1x),
        .cand     (cand),
        .mem_q    (mem_q),
        .last     (last)
    );

    clkdiv_divu #(.W(FREQ_W)) u_divu (
        .clk (clk),
        .rst (rst),
        .go  (div_go),
        .num (src_khz(cand.sel)),
        .den (den),
        .quo (quo),
        .vld (div_vld)
    );

    clkdiv_best u_best (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .upd      ((state_q == ST_WAIT) && div_vld),
        .cand     (cand),
        .mem      (mem_q),
        .freq     (quo),
        .req      (req_q),
        .best     (best),
        .best_err (err_khz)
    );

    assign busy      = (state_q != ST_IDLE);
    assign src_sel   = best.sel;
    assign div_code  = best.div_code;
    assign shift_amt = best.shift;
    assign one_x     = best.one_x;

    // R9: completion is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R9: results hold while idle with no new request
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(err_khz) && $stable(best)));
    // R8: completion is only reported once the search has left its busy phase
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R6: memory-mode results never claim the skipped halving
    assert_mem_result_R6: assert property (@(posedge clk) disable iff (rst)
        (done && mem_q) |-> (!one_x && div_code <= 2'd1));

endmodule

// File: tb/test_clkdiv_search.sv
module test_clkdiv_search;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] req_khz;
    logic        allow_1x;
    logic        mem_mode;
    logic        busy;
    logic        done;
    logic        src_sel;
    logic [1:0]  div_code;
    logic [2:0]  shift_amt;
    logic        one_x;
    logic [31:0] err_khz;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    clkdiv_search i_clkdiv_search (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .req_khz   (req_khz),
        .allow_1x  (allow_1x),
        .mem_mode  (mem_mode),
        .busy      (busy),
        .done      (done),
        .src_sel   (src_sel),
        .div_code  (div_code),
        .shift_amt (shift_amt),
        .one_x     (one_x),
        .err_khz   (err_khz)
    );

    typedef struct packed {
        logic [31:0] req;
        logic        al;
        logic        mm;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'd100000, 1'b1, 1'b0},
        '{32'd25175,  1'b0, 1'b0},
        '{32'd65000,  1'b1, 1'b0},
        '{32'd133000, 1'b0, 1'b1},
        '{32'd50000,  1'b1, 1'b1},
        '{32'd1000,   1'b0, 1'b0},
        '{32'd168000, 1'b0, 1'b0},
        '{32'd40000,  1'b1, 1'b0},
        '{32'd96000,  1'b1, 1'b0}
    };

    task automatic chk(input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Reference search built from R2..R7.
    function automatic void model(input longint req, input bit al, input bit mm,
                                  output bit e_sel, output bit [1:0] e_dc,
                                  output bit [2:0] e_sh, output bit e_ox,
                                  output longint e_err, output int e_lat);
        longint best = 64'h7FFF_FFFF;
        int n = 0;
        int lo = mm ? 0 : (al ? 0 : 1);
        e_sel = 0; e_dc = 0; e_sh = 0; e_ox = 0;
        for (int m = 0; m < 2; m++)
            for (int d = 0; d < (mm ? 2 : 3); d++)
                for (int s = 0; s < 8; s++)
                    for (int h = (mm ? 0 : 1); h >= lo; h--) begin
                        longint src = (m == 1) ? 336000 : 288000;
                        longint f = src / longint'((2 * d + 1) << s << h);
                        longint e = (f >= req) ? f - req : req - f;
                        n++;
                        if (e < best) begin
                            best = e; e_sel = bit'(m); e_dc = 2'(d);
                            e_sh = 3'(s); e_ox = (h == 0) && !mm;
                        end
                    end
        e_err = best;
        e_lat = n * 34;
    endfunction

    // Issue a request; returns cycles from the accepting edge to done.
    task automatic run(input logic [31:0] r, input bit al, input bit mm,
                       input bit poke, output int cyc);
        @(negedge clk);
        req_khz = r; allow_1x = al; mem_mode = mm; start = 1'b1;
        @(posedge clk);
        cyc = 0;
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (poke && cyc == 100) begin
                start = 1'b1; req_khz = 32'd0; allow_1x = 1'b0; mem_mode = 1'b1;
            end
            if (done) break;
            @(posedge clk);
            cyc++;
        end
    endtask

    task automatic run_check(input string rq, input logic [31:0] r,
                             input bit al, input bit mm, input bit poke);
        bit e_sel, e_ox; bit [1:0] e_dc; bit [2:0] e_sh; longint e_err; int e_lat;
        int cyc;
        model(longint'(r), al, mm, e_sel, e_dc, e_sh, e_ox, e_err, e_lat);
        run(r, al, mm, poke, cyc);
        chk(rq, "latency", cyc, e_lat);
        chk(rq, "done", done, 1);
        chk(rq, "src_sel", src_sel, e_sel);
        chk(rq, "div_code", div_code, e_dc);
        chk(rq, "shift_amt", shift_amt, e_sh);
        chk(rq, "one_x", one_x, e_ox);
        chk(rq, "err_khz", err_khz, e_err);
    endtask

    task automatic expect_fields(input string rq, input bit s, input bit [1:0] d,
                                 input bit [2:0] sh, input bit ox, input longint e);
        chk(rq, "src_sel", src_sel, s);
        chk(rq, "div_code", div_code, d);
        chk(rq, "shift_amt", shift_amt, sh);
        chk(rq, "one_x", one_x, ox);
        chk(rq, "err_khz", err_khz, e);
    endtask

    initial begin
        #(3_000_000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; req_khz = '0; allow_1x = 1'b0; mem_mode = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        expect_fields("R1", 0, 2'd0, 3'd0, 0, 64'h7FFF_FFFF);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 against the reference search
        for (int i = 0; i < NV; i++)
            run_check("R2", VECS[i].req, VECS[i].al, VECS[i].mm, 1'b0);

        // R3: halving forced, 288000 not reachable -> 336000/2
        run_check("R3", 32'd288000, 1'b0, 1'b0, 1'b0);
        expect_fields("R3", 1, 2'd0, 3'd0, 0, 120000);
        // R3: 1x permitted -> exact hit on x12 source
        run_check("R3", 32'd288000, 1'b1, 1'b0, 1'b0);
        expect_fields("R3", 0, 2'd0, 3'd0, 1, 0);
        // R5: tie between 288000 and 336000 keeps the first
        run_check("R5", 32'd312000, 1'b1, 1'b0, 1'b0);
        expect_fields("R5", 0, 2'd0, 3'd0, 1, 24000);
        // R4: slowest candidate uses factor 5 (code 2)
        run_check("R4", 32'd0, 1'b0, 1'b0, 1'b0);
        expect_fields("R4", 0, 2'd2, 3'd7, 0, 225);
        // R6: memory mode slowest uses factor 3 (code 1)
        run_check("R6", 32'd0, 1'b1, 1'b1, 1'b0);
        expect_fields("R6", 0, 2'd1, 3'd7, 0, 750);
        // R7: nothing beats the starting bound
        run_check("R7", 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0);
        expect_fields("R7", 0, 2'd0, 3'd0, 0, 64'h7FFF_FFFF);

        // R9: start while busy is ignored; result and latency follow first request
        run_check("R9", 32'd288000, 1'b1, 1'b0, 1'b1);
        expect_fields("R9", 0, 2'd0, 3'd0, 1, 0);
        // R9: done is one cycle and results hold afterwards
        @(negedge clk);
        chk("R9", "done_low", done, 0);
        chk("R9", "busy_low", busy, 0);
        repeat (5) @(negedge clk);
        expect_fields("R9", 0, 2'd0, 3'd0, 1, 0);
        // R8: busy during a search
        @(negedge clk);
        req_khz = 32'd50000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8", "busy", busy, 1);
        repeat (4000) @(negedge clk);
        chk("R8", "busy_end", busy, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule